// File: doc/BRIEF.md
# Serial Register Access Port

This block is a four-wire serial slave that lets an external host reach a bank of 16-bit control and threshold registers. A frame starts when the active-low select goes low. The host then clocks in an 8-bit command and a 16-bit data word, most significant bit first. The command's top bit chooses a read or a write, and its lower seven bits name the register.

The register bank itself sits outside the block, behind a parallel port. A write reaches the bank as a single-cycle strobe that carries the address and the data. The strobe is issued only when the select rises after exactly twenty-four clocked bits. A read raises a single-cycle read strobe once the command byte is complete. It takes the bank's data in that same cycle and shifts the word out on the serial output.

All serial inputs pass through synchronizers on the system clock, so the serial clock must stay slow compared with the system clock. Each serial clock phase must last at least `SYNC_STAGES + 4` system clocks.

Top module: `sreg_spi_port`

## Requirements
- R1: A frame is 8 command bits followed by 16 data bits, each sampled on a rising serial clock edge, most significant bit first. Command bit 7 set means read and clear means write. Command bits 6:0 give the register address.
- R2: A write frame (bit 7 clear) that sees exactly 24 rising edges before the select rises produces exactly one `wr_stb` pulse, one system clock wide. The pulse carries `wr_addr` equal to command bits 6:0 and `wr_data` equal to the 16 data bits.
- R3: A frame whose select rises after fewer than 24 rising edges is discarded: no `wr_stb` pulse and no register change.
- R4: A frame with more than 24 rising edges is discarded in the same way.
- R5: After the 8th rising edge of a read frame, `rd_stb` pulses once for one clock with `rd_addr` equal to command bits 6:0. The word is then driven on `spi_dout`, MSB first. D15 is valid before the 9th rising edge, and each following bit appears after the next falling edge.
- R6: With the default mask, only addresses 0x20, 0x22, 0x24, 0x26, 0x28, 0x2A, 0x2C and 0x2E are readable. A read of any other address, including the write-only address 0x62, returns 0x0000 whatever the bank holds.
- R7: A read frame never produces a `wr_stb` pulse, even when the select rises after the full 24 bits.
- R8: While the select is high, `spi_dout` and `spi_dout_en` are both low.
- R9: After reset, `wr_stb`, `rd_stb`, `spi_dout` and `spi_dout_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_din | input | 1 | Serial data from host |
| spi_dout | output | 1 | Serial read data, low when not driving |
| spi_dout_en | output | 1 | High while read data is being driven |
| wr_stb | output | 1 | One-clock write strobe to the register bank |
| wr_addr | output | 7 | Write address |
| wr_data | output | 16 | Write data |
| rd_stb | output | 1 | One-clock read strobe to the register bank |
| rd_addr | output | 7 | Read address |
| rd_data | input | 16 | Read data returned by the bank in the `rd_stb` cycle |

## Verification
A bit counter that is off by one shows up within a single frame, as a missing or extra `wr_stb` at the select's rise. It also shows as a read word that is shifted by one position on `spi_dout`. A wrong read/write decode or a wrong readability decode shows when the same register is read back in the next frame: the returned word differs from what was written, or from zero for hidden addresses. Output-shift state that is not cleared between frames shows as stray data on `spi_dout` while the select is high, or at the head of the next read.

// File: rtl/sreg_spi_pkg.sv
package sreg_spi_pkg;
   // index of each serial input inside the synchronizer vector
   localparam int unsigned SIG_SCK = 0;
   localparam int unsigned SIG_CSN = 1;
   localparam int unsigned SIG_DIN = 2;
   localparam int unsigned SIG_W   = 3;
   // idle levels: clock low, select high, data low
   localparam logic [SIG_W-1:0] SIG_IDLE = 3'b010;

   function automatic int unsigned cnt_width(input int unsigned frame_bits);
      return $clog2(frame_bits + 2);
   endfunction
endpackage

// File: rtl/sspi_sync.sv
module sspi_sync #(
   parameter int unsigned W       = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q,
   output logic [W-1:0] q_rise,
   output logic [W-1:0] q_fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sspi_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] pipe [STAGES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i <= STAGES; i++) pipe[i] <= RST_VAL;
      end else begin
         pipe[0] <= d_in;
         for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q      = pipe[STAGES-1];
   assign q_rise = pipe[STAGES-1] & ~pipe[STAGES];
   assign q_fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/sspi_frame.sv
module sspi_frame
   import sreg_spi_pkg::*;
#(
   parameter int unsigned CMD_W  = 8,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned FRAME_W = CMD_W + DATA_W,
   localparam int unsigned ADDR_W  = CMD_W - 1,
   localparam int unsigned CNT_W   = cnt_width(FRAME_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              cs_rise,
   input  logic              sck_rise,
   input  logic              din,
   output logic [CNT_W-1:0]  bit_cnt,
   output logic              cmd_hit,
   output logic [CMD_W-1:0]  cmd,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   localparam logic [CNT_W-1:0] CNT_CMD_LAST = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_OVER     = CNT_W'(FRAME_W + 1);

   logic [FRAME_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr      <= '0;
         bit_cnt <= '0;
         cmd_hit <= 1'b0;
      end else begin
         cmd_hit <= cs_act & sck_rise & (bit_cnt == CNT_CMD_LAST);
         if (!cs_act) begin
            bit_cnt <= '0;
         end else if (sck_rise) begin
            sr <= {sr[FRAME_W-2:0], din};
            if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   assign cmd = sr[CMD_W-1:0];

   // commit: select rises with exactly a full frame held and write flag clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= cs_rise & (bit_cnt == CNT_FULL) & ~sr[FRAME_W-1];
         if (cs_rise & (bit_cnt == CNT_FULL) & ~sr[FRAME_W-1]) begin
            wr_addr <= sr[FRAME_W-2:DATA_W];
            wr_data <= sr[DATA_W-1:0];
         end
      end
   end

   a_r2_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
   a_r2_wr_after_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !cs_act);
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_OVER);
endmodule

// File: rtl/sspi_rdout.sv
module sspi_rdout
   import sreg_spi_pkg::*;
#(
   parameter int unsigned CMD_W  = 8,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned FRAME_W = CMD_W + DATA_W,
   localparam int unsigned ADDR_W  = CMD_W - 1,
   localparam int unsigned CNT_W   = cnt_width(FRAME_W),
   parameter logic [(2**ADDR_W)-1:0] RD_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sck_fall,
   input  logic [CNT_W-1:0]  bit_cnt,
   input  logic              cmd_hit,
   input  logic [CMD_W-1:0]  cmd,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rd_stb,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              dout,
   output logic              dout_en
);
   localparam logic [CNT_W-1:0] SHIFT_LO = CNT_W'(CMD_W + 1);
   localparam logic [CNT_W-1:0] SHIFT_HI = CNT_W'(FRAME_W - 1);

   logic [DATA_W-1:0] osr;
   logic              rd_act;

   assign rd_stb  = cmd_hit & cmd[CMD_W-1];
   assign rd_addr = cmd[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osr    <= '0;
         rd_act <= 1'b0;
      end else if (!cs_act) begin
         osr    <= '0;
         rd_act <= 1'b0;
      end else if (rd_stb) begin
         osr    <= RD_MASK[rd_addr] ? rd_data : '0;
         rd_act <= 1'b1;
      end else if (sck_fall && bit_cnt >= SHIFT_LO && bit_cnt <= SHIFT_HI) begin
         osr <= {osr[DATA_W-2:0], 1'b0};
      end
   end

   assign dout_en = rd_act & cs_act;
   assign dout    = dout_en & osr[DATA_W-1];

   a_r5_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !rd_stb);
   a_r8_osr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (osr == '0) && !rd_act);
endmodule

// File: rtl/sreg_spi_port.sv
module sreg_spi_port
   import sreg_spi_pkg::*;
#(
   parameter int unsigned CMD_W       = 8,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [(2**(CMD_W-1))-1:0] RD_MASK =
      128'h0000_0000_0000_0000_0000_5555_0000_0000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                spi_sck,
   input  logic                spi_cs_n,
   input  logic                spi_din,
   output logic                spi_dout,
   output logic                spi_dout_en,
   output logic                wr_stb,
   output logic [CMD_W-2:0]    wr_addr,
   output logic [DATA_W-1:0]   wr_data,
   output logic                rd_stb,
   output logic [CMD_W-2:0]    rd_addr,
   input  logic [DATA_W-1:0]   rd_data
);
   localparam int unsigned FRAME_W = CMD_W + DATA_W;
   localparam int unsigned CNT_W   = cnt_width(FRAME_W);

   generate
      if (CMD_W < 2) begin : g_bad_cmd
         $error("sreg_spi_port: CMD_W must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("sreg_spi_port: DATA_W must be at least 2");
      end
   endgenerate

   logic [SIG_W-1:0] s_q, s_rise, s_fall;
   logic             cs_act, cs_rise, sck_rise, sck_fall;
   logic [CNT_W-1:0] bit_cnt;
   logic             cmd_hit;
   logic [CMD_W-1:0] cmd;
   logic             unused_edges;

   sspi_sync #(.W(SIG_W), .STAGES(SYNC_STAGES), .RST_VAL(SIG_IDLE)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .d_in({spi_din, spi_cs_n, spi_sck}),
      .q(s_q), .q_rise(s_rise), .q_fall(s_fall)
   );

   assign cs_act       = ~s_q[SIG_CSN];
   assign cs_rise      = s_rise[SIG_CSN];
   assign sck_rise     = s_rise[SIG_SCK];
   assign sck_fall     = s_fall[SIG_SCK];
   assign unused_edges = ^{s_rise[SIG_DIN], s_fall[SIG_DIN], s_fall[SIG_CSN]};

   sspi_frame #(.CMD_W(CMD_W), .DATA_W(DATA_W)) i_frame (
      .clk(clk), .rst_n(rst_n),
      .cs_act(cs_act), .cs_rise(cs_rise), .sck_rise(sck_rise),
      .din(s_q[SIG_DIN]),
      .bit_cnt(bit_cnt), .cmd_hit(cmd_hit), .cmd(cmd),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   sspi_rdout #(.CMD_W(CMD_W), .DATA_W(DATA_W), .RD_MASK(RD_MASK)) i_rdout (
      .clk(clk), .rst_n(rst_n),
      .cs_act(cs_act), .sck_fall(sck_fall), .bit_cnt(bit_cnt),
      .cmd_hit(cmd_hit), .cmd(cmd), .rd_data(rd_data),
      .rd_stb(rd_stb), .rd_addr(rd_addr),
      .dout(spi_dout), .dout_en(spi_dout_en)
   );

   a_r8_dout_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |-> !spi_dout && !spi_dout_en);
   a_r7_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && rd_stb));
endmodule

// File: tb/test_sreg_spi_port.sv
module test_sreg_spi_port;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_SCK   = 8;
   localparam int NVEC       = 10;
   // {write command, write data, expected readback}
   localparam logic [39:0] VEC [NVEC] = '{
      {8'h20, 16'h02A8, 16'h02A8},
      {8'h22, 16'h0EC0, 16'h0EC0},
      {8'h24, 16'h02C1, 16'h02C1},
      {8'h26, 16'h0011, 16'h0011},
      {8'h28, 16'hFFFF, 16'hFFFF},
      {8'h2A, 16'h0000, 16'h0000},
      {8'h2C, 16'h8001, 16'h8001},
      {8'h2E, 16'h1234, 16'h1234},
      {8'h62, 16'h00F0, 16'h0000},
      {8'h10, 16'hABCD, 16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sck = 1'b0, spi_cs_n = 1'b1, spi_din = 1'b0;
   logic        spi_dout, spi_dout_en;
   logic        wr_stb, rd_stb;
   logic [6:0]  wr_addr, rd_addr;
   logic [15:0] wr_data, rd_data;
   logic [15:0] regmem [128];
   int          n_chk = 0, n_fail = 0;
   int          wr_cnt = 0, rd_cnt = 0;
   logic [6:0]  last_wa, last_ra;
   logic [15:0] last_wd;
   logic        done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sreg_spi_port i_sreg_spi_port (
      .clk(clk), .rst_n(rst_n),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_din(spi_din),
      .spi_dout(spi_dout), .spi_dout_en(spi_dout_en),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   assign rd_data = regmem[rd_addr];

   always @(posedge clk) begin
      if (wr_stb) begin
         regmem[wr_addr] <= wr_data;
         wr_cnt  <= wr_cnt + 1;
         last_wa <= wr_addr;
         last_wd <= wr_data;
      end
      if (rd_stb) begin
         rd_cnt  <= rd_cnt + 1;
         last_ra <= rd_addr;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic frame(input int nbits, input logic [31:0] val, output logic [15:0] rx);
      rx = '0;
      @(negedge clk);
      spi_cs_n = 1'b0;
      repeat (HALF_SCK) @(negedge clk);
      for (int i = nbits - 1; i >= 0; i--) begin
         spi_sck = 1'b0;
         spi_din = val[i];
         repeat (HALF_SCK) @(negedge clk);
         rx = {rx[14:0], spi_dout};
         spi_sck = 1'b1;
         repeat (HALF_SCK) @(negedge clk);
      end
      spi_sck = 1'b0;
      repeat (HALF_SCK) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] rx;
      int w0, r0;
      for (int i = 0; i < 128; i++) regmem[i] = 16'hC0DE;
      repeat (4) @(negedge clk);
      // R9: reset state
      chk("R9 wr_stb", {31'd0, wr_stb}, 0);
      chk("R9 rd_stb", {31'd0, rd_stb}, 0);
      chk("R9 dout", {30'd0, spi_dout, spi_dout_en}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 R2 R5 R6: table of write then read-back
      for (int v = 0; v < NVEC; v++) begin
         w0 = wr_cnt;
         frame(24, {8'h00, VEC[v][39:32], VEC[v][31:16]}, rx);
         chk("R2 one write strobe", wr_cnt - w0, 1);
         chk("R1 R2 write addr/data", {9'd0, last_wa, last_wd},
             {9'd0, VEC[v][38:32], VEC[v][31:16]});
         w0 = wr_cnt;
         r0 = rd_cnt;
         frame(24, {8'h00, VEC[v][39:32] | 8'h80, 16'h0000}, rx);
         chk("R5 R6 readback", {16'd0, rx}, {16'd0, VEC[v][15:0]});
         chk("R5 rd_stb addr", {rd_cnt - r0, 1'b0, last_ra}, {32'd1 << 8} | {25'd0, VEC[v][38:32]});
         chk("R7 read no write", wr_cnt - w0, 0);
         chk("R8 dout idle", {30'd0, spi_dout, spi_dout_en}, 0);
      end

      // R3: select rises after 20 bits
      w0 = wr_cnt;
      frame(20, {12'h0, 8'h20, 12'h555}, rx);
      chk("R3 short frame no write", wr_cnt - w0, 0);
      frame(24, {8'h00, 8'hA0, 16'h0000}, rx);
      chk("R3 value kept", {16'd0, rx}, 32'h02A8);

      // R4: select rises after 25 bits
      w0 = wr_cnt;
      frame(25, {7'h0, 8'h22, 16'h5A5A, 1'b1}, rx);
      chk("R4 long frame no write", wr_cnt - w0, 0);
      frame(24, {8'h00, 8'hA2, 16'h0000}, rx);
      chk("R4 value kept", {16'd0, rx}, 32'h0EC0);

      // R7: read frame with nonzero data bits and a full 24 bits
      w0 = wr_cnt;
      frame(24, {8'h00, 8'hA4, 16'hFFFF}, rx);
      chk("R7 read full frame no write", wr_cnt - w0, 0);
      chk("R7 R5 readback", {16'd0, rx}, 32'h02C1);

      // R6: hidden address holds data in bank yet reads zero
      frame(24, {8'h00, 8'hE2, 16'h0000}, rx);
      chk("R6 write-only reads zero", {16'd0, rx}, 0);
      chk("R6 bank holds value", {16'd0, regmem[7'h62]}, 32'h00F0);

      // R8: idle output after everything
      repeat (5) @(negedge clk);
      chk("R8 dout idle final", {30'd0, spi_dout, spi_dout_en}, 0);
      finish_run();
   end
endmodule